// File: doc/BRIEF.md
# Packet Descriptor Ring Walker

This block walks a software-built chain of packet descriptors in host memory for one transfer direction. Each descriptor is a record of three consecutive 32-bit words: the buffer start address, a control word carrying the ownership semaphore, override bits and packet length, and a link to the next record. Software writes the address of the first record into the pointer input. The walker then reads each record through a single 32-bit memory port and hands every valid packet to a data mover. When the mover reports completion, the walker writes the control word back, raises an interrupt pulse and follows the link. Software closes the chain into a ring by pointing the last link back at the first record.

The ownership bit is the top bit of the control word, bit 31. When it is set, the record belongs to the hardware: for transmit it means the buffer holds a packet, and for receive it means the buffer is free. The walker clears the bit when it is done, so software may either poll the bit or count interrupts. A record whose bit is already clear stops the walk. The walker then sits in a halted state until software pulses `kick`, which re-reads the same record, or writes a new pointer. Lengths above the standard maximum frame are rejected. Such a record is released with its bit cleared and an `err` pulse, and the walk continues with the next record.

The build parameter `RX_MODE` selects the direction. A receive build writes the length reported by the mover into the length field. A transmit build keeps the original length. The memory port uses `mem_req`/`mem_ready` as a valid/ready pair; read data returns later on `mem_rvalid`. The job interface is valid/ready too: `job_valid` and its payload stay unchanged until `job_ready` is seen high at a clock edge. `mover_done` is a plain one-cycle pulse.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, and until the first pointer write, `mem_req`, `job_valid`, `irq` and `err` stay low.
- R2: A pointer write while idle starts a walk. The walker reads words at P, P+4 and P+8 in that order, where P is the written pointer with bits [1:0] forced to zero.
- R3: If the fetched control word has bit 31 clear, the walker issues no job and makes no further memory access. A later `kick` pulse re-reads the same three words.
- R4: For an owned record, the job presents `job_addr` = word 0 with bits [1:0] zero, `job_len` = control bits [15:0] and `job_ovr` = control bits [20:16]. The job and its payload are held steady until `job_ready` is high.
- R5: A length greater than MAX_LEN (1518) gives no job. A length equal to 1518 is accepted. The rejected record gets its control word written back with bit 31 cleared, and produces one `err` pulse and no `irq`.
- R6: Completion causes exactly one write, to record address + 4. The written data has bit 31 zero, bits [30:21] zero, the override bits unchanged and, in a receive build, bits [15:0] equal to `mover_len`.
- R7: Every completed packet gives exactly one single-cycle `irq` pulse.
- R8: After the write-back, the walker fetches the record whose address is word 2 with bits [1:0] zero, so a linked ring is revisited.
- R9: A pointer write is ignored while a walk is in progress. In the halted state, a pointer write restarts the walk at the new pointer, even when `kick` is high in the same cycle.
- R10: While `mem_req` is high and `mem_ready` is low, the request address, write enable and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_addr | input | 32 | Address of the first descriptor |
| kick | input | 1 | Resume pulse for a halted walk |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| job_valid | output | 1 | Packet job valid |
| job_ready | input | 1 | Data mover accepts the job |
| job_addr | output | 32 | Packet buffer address |
| job_len | output | 16 | Packet length in bytes |
| job_ovr | output | 5 | Override bits passed through |
| mover_done | input | 1 | Data mover completion pulse |
| mover_len | input | 16 | Received length, valid with `mover_done` |
| irq | output | 1 | One pulse per completed packet |
| err | output | 1 | One pulse per rejected oversize record |

## Verification
Two events can arrive in the same cycle at a halted walker: a new pointer write and a `kick` pulse. The bench drives both on one falling edge. It then checks the address log of the memory model: the next three reads must start at the new pointer and not at the halted record. A second overlap occurs when a pointer write arrives while a job is held back by a low `job_ready`. There, the read log after completion must show the walk continuing at the link target of the current record.

// File: rtl/drw_pkg.sv
package drw_pkg;
  localparam int WORD_W = 32;
  localparam int REC_WORDS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RDW,
    ST_CHECK,
    ST_JOB,
    ST_MOVE,
    ST_WB,
    ST_HALT
  } drw_state_e;

  localparam logic [WORD_W-1:0] ALIGN_MASK = ~32'h3;
endpackage

// File: rtl/drw_desc_store.sv
module drw_desc_store
  import drw_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int OVR_W   = 5,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  output logic [WORD_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  len,
  output logic [OVR_W-1:0]  ovr,
  output logic              owned,
  output logic              too_long,
  output logic [WORD_W-1:0] link
);
  localparam int CTL_W = 1 + OVR_W + LEN_W;
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic [WORD_W-1:0] buf_q, link_q;
  logic [CTL_W-1:0]  ctl_q;

  // word 0: buffer address, word 1: flag/override/length, word 2: link
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      ctl_q  <= '0;
      link_q <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        2'd0:    buf_q  <= cap_word;
        2'd1:    ctl_q  <= {cap_word[WORD_W-1], cap_word[OVR_W+LEN_W-1:0]};
        default: link_q <= cap_word;
      endcase
    end
  end

  assign buf_addr = buf_q & ALIGN_MASK;
  assign link     = link_q & ALIGN_MASK;
  assign owned    = ctl_q[CTL_W-1];
  assign ovr      = ctl_q[OVR_W+LEN_W-1:LEN_W];
  assign len      = ctl_q[LEN_W-1:0];
  assign too_long = len > MAX_L;

  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_addr[1:0] == 2'b00 && link[1:0] == 2'b00);
endmodule

// File: rtl/drw_ctrl.sv
module drw_ctrl
  import drw_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [WORD_W-1:0] ptr_addr,
  input  logic              kick,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic              owned,
  input  logic              too_long,
  input  logic [WORD_W-1:0] link,
  input  logic              job_ready,
  input  logic              mover_done,
  input  logic [LEN_W-1:0]  mover_len,
  output drw_state_e        st,
  output logic [WORD_W-1:0] cur,
  output logic [1:0]        idx,
  output logic              skip,
  output logic [LEN_W-1:0]  rlen,
  output logic              irq,
  output logic              err
);
  localparam logic [1:0] LAST_IDX = 2'(REC_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cur  <= '0;
      idx  <= '0;
      skip <= 1'b0;
      rlen <= '0;
      irq  <= 1'b0;
      err  <= 1'b0;
    end else begin
      irq <= 1'b0;
      err <= 1'b0;
      case (st)
        ST_IDLE: if (ptr_wr) begin
          cur <= ptr_addr & ALIGN_MASK;
          idx <= '0;
          st  <= ST_RD;
        end
        ST_HALT: begin
          if (ptr_wr) begin
            cur <= ptr_addr & ALIGN_MASK;
            idx <= '0;
            st  <= ST_RD;
          end else if (kick) begin
            idx <= '0;
            st  <= ST_RD;
          end
        end
        ST_RD: if (mem_ready) st <= ST_RDW;
        ST_RDW: if (mem_rvalid) begin
          if (idx == LAST_IDX) st <= ST_CHECK;
          else begin
            idx <= idx + 2'd1;
            st  <= ST_RD;
          end
        end
        ST_CHECK: begin
          if (!owned) st <= ST_HALT;
          else if (too_long) begin
            skip <= 1'b1;
            st   <= ST_WB;
          end else begin
            skip <= 1'b0;
            st   <= ST_JOB;
          end
        end
        ST_JOB: if (job_ready) st <= ST_MOVE;
        ST_MOVE: if (mover_done) begin
          rlen <= mover_len;
          st   <= ST_WB;
        end
        ST_WB: if (mem_ready) begin
          irq <= !skip;
          err <= skip;
          cur <= link;
          idx <= '0;
          st  <= ST_RD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && err));
  assert_halt_no_job_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && !owned) |=> st == ST_HALT);
  assert_busy_keeps_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_JOB || st == ST_MOVE) |=> $stable(cur));
endmodule

// File: rtl/drw_bus_drive.sv
module drw_bus_drive
  import drw_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int OVR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  drw_state_e        st,
  input  logic [WORD_W-1:0] cur,
  input  logic [1:0]        idx,
  input  logic [OVR_W-1:0]  wb_ovr,
  input  logic [LEN_W-1:0]  wb_len,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam int RSV_W = WORD_W - 1 - OVR_W - LEN_W;

  always_comb begin
    mem_req   = (st == ST_RD) || (st == ST_WB);
    mem_we    = (st == ST_WB);
    mem_addr  = mem_we ? cur + 32'd4 : cur + {28'd0, idx, 2'b00};
    mem_wdata = mem_we ? {1'b0, {RSV_W{1'b0}}, wb_ovr, wb_len} : '0;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata));
  assert_wb_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[WORD_W-1] == 1'b0);
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
  import drw_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int OVR_W   = 5,
  parameter int MAX_LEN = 1518,
  parameter bit RX_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [31:0]       ptr_addr,
  input  logic              kick,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              job_valid,
  input  logic              job_ready,
  output logic [31:0]       job_addr,
  output logic [LEN_W-1:0]  job_len,
  output logic [OVR_W-1:0]  job_ovr,
  input  logic              mover_done,
  input  logic [LEN_W-1:0]  mover_len,
  output logic              irq,
  output logic              err
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  drw_state_e        st;
  logic [WORD_W-1:0] cur, link, buf_addr;
  logic [1:0]        idx;
  logic              skip, owned, too_long;
  logic [LEN_W-1:0]  rlen, d_len, wb_len;
  logic [OVR_W-1:0]  d_ovr;

  drw_desc_store #(.LEN_W(LEN_W), .OVR_W(OVR_W), .MAX_LEN(MAX_LEN)) store_i (
    .clk(clk), .rst_n(rst_n),
    .cap_en(st == ST_RDW && mem_rvalid), .cap_idx(idx), .cap_word(mem_rdata),
    .buf_addr(buf_addr), .len(d_len), .ovr(d_ovr), .owned(owned),
    .too_long(too_long), .link(link)
  );

  drw_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_addr(ptr_addr),
    .kick(kick), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .owned(owned), .too_long(too_long), .link(link),
    .job_ready(job_ready), .mover_done(mover_done), .mover_len(mover_len),
    .st(st), .cur(cur), .idx(idx), .skip(skip), .rlen(rlen),
    .irq(irq), .err(err)
  );

  generate
    if (RX_MODE) begin : g_rx_len
      assign wb_len = skip ? d_len : rlen;
    end else begin : g_tx_len
      assign wb_len = d_len;
    end
  endgenerate

  drw_bus_drive #(.LEN_W(LEN_W), .OVR_W(OVR_W)) bus_i (
    .clk(clk), .rst_n(rst_n), .st(st), .cur(cur), .idx(idx),
    .wb_ovr(d_ovr), .wb_len(wb_len), .mem_ready(mem_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign job_valid = (st == ST_JOB);
  assign job_addr  = buf_addr;
  assign job_len   = d_len;
  assign job_ovr   = d_ovr;

  assert_no_jumbo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> job_len <= MAX_L);
  assert_job_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && !job_ready) |=> job_valid && $stable(job_addr) &&
                                  $stable(job_len) && $stable(job_ovr));
endmodule

// File: tb/desc_ring_walker_tb_top.sv
module desc_ring_walker_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ptr_wr, kick, mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] ptr_addr, mem_addr, mem_wdata, mem_rdata, job_addr;
  logic job_valid, job_ready, mover_done, irq, err;
  logic [15:0] job_len, mover_len, rx_len;
  logic [4:0] job_ovr;

  desc_ring_walker #(.RX_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_addr(ptr_addr),
    .kick(kick), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_len(job_len), .job_ovr(job_ovr),
    .mover_done(mover_done), .mover_len(mover_len), .irq(irq), .err(err)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // host memory model with logs
  logic [31:0] mem [0:63];
  logic [31:0] rd_log [0:63];
  logic [31:0] wa_log [0:63];
  logic [31:0] wd_log [0:63];
  logic [31:0] ja_log [0:15];
  logic [15:0] jl_log [0:15];
  logic [4:0]  jo_log [0:15];
  int rd_n, wr_n, job_n, irq_n, err_n, irq_run, irq_max;
  logic [3:0] rdy_cnt, mv_cnt;
  logic host_we, jr_block;
  logic [5:0] host_idx;
  logic [31:0] host_data;

  assign mem_ready = rdy_cnt[1:0] != 2'b00;
  assign job_ready = !jr_block;

  always @(posedge clk) begin
    if (!rst_n) begin
      rdy_cnt <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      rd_n <= 0; wr_n <= 0; job_n <= 0; irq_n <= 0; err_n <= 0;
      irq_run <= 0; irq_max <= 0; mv_cnt <= '0; mover_done <= 1'b0;
      mover_len <= '0;
    end else begin
      rdy_cnt <= rdy_cnt + 4'd1;
      mem_rvalid <= 1'b0;
      mover_done <= 1'b0;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[7:2]] <= mem_wdata;
          wa_log[wr_n[5:0]] <= mem_addr;
          wd_log[wr_n[5:0]] <= mem_wdata;
          wr_n <= wr_n + 1;
        end else begin
          mem_rdata <= mem[mem_addr[7:2]];
          mem_rvalid <= 1'b1;
          rd_log[rd_n[5:0]] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
      if (job_valid && job_ready) begin
        ja_log[job_n[3:0]] <= job_addr;
        jl_log[job_n[3:0]] <= job_len;
        jo_log[job_n[3:0]] <= job_ovr;
        job_n <= job_n + 1;
        mv_cnt <= 4'd4;
      end else if (mv_cnt != 0) begin
        mv_cnt <= mv_cnt - 4'd1;
        if (mv_cnt == 4'd1) begin
          mover_done <= 1'b1;
          mover_len <= rx_len;
        end
      end
      if (irq) begin
        irq_n <= irq_n + 1;
        irq_run <= irq_run + 1;
        if (irq_run + 1 > irq_max) irq_max <= irq_run + 1;
      end else irq_run <= 0;
      if (err) err_n <= err_n + 1;
    end
    if (host_we) mem[host_idx] <= host_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [5:0] i, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = i; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse(input logic do_ptr, input logic [31:0] p, input logic do_kick);
    @(negedge clk);
    ptr_wr = do_ptr; ptr_addr = p; kick = do_kick;
    @(negedge clk);
    ptr_wr = 1'b0; kick = 1'b0;
  endtask

  task automatic t_reset;
    bit bad = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (mem_req || job_valid || irq || err) bad = 1;
    end
    chk("R1 quiet after reset", {31'd0, bad}, 32'd0);
    chk("R1 no reads", rd_n, 0);
  endtask

  task automatic t_ring;
    poke(6'd0, 32'h0000_1003);
    poke(6'd1, 32'h8000_0000 | (32'h0A << 16) | 32'd64);
    poke(6'd2, 32'h0000_0012);
    poke(6'd4, 32'h0000_2000);
    poke(6'd5, 32'h8000_0000 | 32'd2000);
    poke(6'd6, 32'h0000_0020);
    poke(6'd8, 32'h0000_3000);
    poke(6'd9, 32'h8000_0000 | (32'h01 << 16) | 32'd1518);
    poke(6'd10, 32'h0000_0000);
    pulse(1'b1, 32'h0000_0002, 1'b0);
    repeat (300) @(negedge clk);
    chk("R2 read0", rd_log[0], 32'h0);
    chk("R2 read1", rd_log[1], 32'h4);
    chk("R2 read2", rd_log[2], 32'h8);
    chk("R8 next record", rd_log[3], 32'h10);
    chk("R8 third record", rd_log[6], 32'h20);
    chk("R8 ring wraps", rd_log[9], 32'h0);
    chk("R3 halted read count", rd_n, 12);
    chk("R4 job count", job_n, 2);
    chk("R4 job addr", ja_log[0], 32'h1000);
    chk("R4 job len", {16'd0, jl_log[0]}, 32'd64);
    chk("R4 job ovr", {27'd0, jo_log[0]}, 32'h0A);
    chk("R5 boundary job addr", ja_log[1], 32'h3000);
    chk("R5 boundary job len", {16'd0, jl_log[1]}, 32'd1518);
    chk("R6 write count", wr_n, 3);
    chk("R6 wb addr", wa_log[0], 32'h4);
    chk("R6 wb data", wd_log[0], 32'h000A_003C);
    chk("R5 skip wb addr", wa_log[1], 32'h14);
    chk("R5 skip wb data", wd_log[1], 32'h0000_07D0);
    chk("R6 wb data rec3", wd_log[2], 32'h0001_003C);
    chk("R7 irq count", irq_n, 2);
    chk("R5 err count", err_n, 1);
    chk("R7 irq width", irq_max, 1);
  endtask

  task automatic t_kick_backpressure;
    logic [31:0] held;
    bit bad = 0;
    rx_len = 16'd77;
    poke(6'd1, 32'h8000_0000 | 32'd100);
    jr_block = 1'b1;
    pulse(1'b0, 32'h0, 1'b1);
    for (int i = 0; i < 200 && !job_valid; i++) @(negedge clk);
    held = job_addr;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        ptr_wr = 1'b1; ptr_addr = 32'h30;
      end else ptr_wr = 1'b0;
      @(negedge clk);
      if (!job_valid || job_addr !== held) bad = 1;
    end
    ptr_wr = 1'b0;
    chk("R4 job held under back-pressure", {31'd0, bad}, 32'd0);
    jr_block = 1'b0;
    repeat (150) @(negedge clk);
    chk("R3 kick rereads same record", rd_log[12], 32'h0);
    chk("R3 kick reread word2", rd_log[14], 32'h8);
    chk("R4 job after kick", ja_log[2], 32'h1000);
    chk("R6 rx length written", wd_log[3], 32'h0000_004D);
    chk("R9 busy ptr ignored", rd_log[15], 32'h10);
    chk("R3 halts on cleared record", rd_n, 18);
    chk("R7 irq count after kick", irq_n, 3);
  endtask

  task automatic t_collide;
    poke(6'd13, 32'h0000_0000);
    pulse(1'b1, 32'h30, 1'b1);
    repeat (80) @(negedge clk);
    chk("R9 ptr beats kick", rd_log[18], 32'h30);
    chk("R9 new record words", rd_log[20], 32'h38);
    chk("R3 no job on cleared flag", job_n, 3);
    chk("R3 stops after one record", rd_n, 21);
  endtask

  initial begin
    rst_n = 1'b0; ptr_wr = 1'b0; kick = 1'b0; ptr_addr = '0;
    host_we = 1'b0; host_idx = '0; host_data = '0; jr_block = 1'b0;
    rx_len = 16'd60;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    t_reset();
    t_ring();
    t_kick_backpressure();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule